// File: doc/BRIEF.md
# Tagged Branch Type Table

This block sits beside the fetch stage and answers, for every fetch address, whether the instruction there is a branch the machine has seen before. When it is, the block also reports what sort of branch it is and where it goes. The storage is direct-mapped. The low bits of the 32-bit PC select one slot. The remaining upper bits are kept as a tag, so that two PCs sharing a slot are not confused.

The lookup side is purely combinational. A PC presented in a cycle produces hit, kind and target in that same cycle. The update side is used by later pipeline stages once a branch has resolved. It writes the branch's PC, kind and target at the next rising clock edge. Only branches are ever written.

Any lookup that finds an empty slot, or a slot holding another PC's tag, is read as "not a branch". An update always overwrites its slot, whatever that slot held before.

Top module: `branch_type_table`

## Requirements
- R1: After synchronous reset every slot is empty, so every lookup reports lk_hit = 0 until an update writes that slot.
- R2: A lookup whose slot is valid and whose stored tag equals lk_pc[31:IDX_W] reports lk_hit = 1 in the same cycle, together with the stored kind and target.
- R3: A lookup at an occupied slot whose stored tag differs from the upper PC bits reports lk_hit = 0.
- R4: An update with up_en = 1 takes effect at the rising edge that samples it, and a lookup of the same PC in the following cycle hits with the written kind and target.
- R5: An update to a slot already holding another tag replaces that entry. The old PC then misses, and the new PC hits.
- R6: When a lookup and an update address the same slot in the same cycle, the lookup returns the contents from before the update.
- R7: The kind field is encoded as 2'b00 unconditional jump, 2'b01 conditional branch, 2'b10 call, 2'b11 return. Each code is returned exactly as it was written.
- R8: The slot is selected by lk_pc[IDX_W-1:0] (default IDX_W = 10, 1024 slots). An update to one slot leaves the lookup result of every other slot unchanged, including slot 0 and the last slot.
- R9: Whenever lk_hit = 0, lk_kind and lk_target are driven to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; empties all slots |
| lk_pc | input | 32 | Fetch PC to look up |
| lk_hit | output | 1 | Known branch at lk_pc |
| lk_kind | output | 2 | Branch kind code (R7), zero on miss |
| lk_target | output | 32 | Stored target PC, zero on miss |
| up_en | input | 1 | Write a resolved branch this cycle |
| up_pc | input | 32 | PC of the resolved branch |
| up_kind | input | 2 | Kind code of the resolved branch |
| up_target | input | 32 | Target PC of the resolved branch |

## Verification
Lookup results are combinational. The bench therefore drives lk_pc on a falling edge and samples one nanosecond later, inside the same cycle. An update driven on a falling edge is captured by the next rising edge. Its effect is first checked on the following falling edge, one cycle after the stimulus.

For the same-slot collision, the bench samples twice. It samples before the rising edge to see the old contents, and again after the edge to see the new ones. The checker adds a one-cycle check that a written PC hits with its written fields, and a check that lookups stay stable across updates to other slots.

// File: rtl/btt_pkg.sv
package btt_pkg;

    localparam int unsigned PC_W = 32;

    typedef enum logic [1:0] {
        KIND_JUMP = 2'b00,
        KIND_COND = 2'b01,
        KIND_CALL = 2'b10,
        KIND_RET  = 2'b11
    } btt_kind_e;

    typedef struct packed {
        logic      hit;
        btt_kind_e kind;
        logic [PC_W-1:0] target;
    } btt_result_t;

    function automatic btt_result_t btt_miss();
        btt_result_t r;
        r.hit    = 1'b0;
        r.kind   = KIND_JUMP;
        r.target = '0;
        return r;
    endfunction

endpackage

// File: rtl/btt_split.sv
module btt_split
    import btt_pkg::*;
#(
    parameter int unsigned IDX_W = 10,
    localparam int unsigned TAG_W = PC_W - IDX_W
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag
);
    assign idx = pc[IDX_W-1:0];
    assign tag = pc[PC_W-1:IDX_W];
endmodule

// File: rtl/btt_store.sv
module btt_store
    import btt_pkg::*;
#(
    parameter int unsigned IDX_W = 10,
    localparam int unsigned TAG_W   = PC_W - IDX_W,
    localparam int unsigned ENTRIES = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  btt_kind_e        wr_kind,
    input  logic [PC_W-1:0]  wr_target,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output btt_kind_e        rd_kind,
    output logic [PC_W-1:0]  rd_target
);
    typedef struct packed {
        logic [TAG_W-1:0] tag;
        btt_kind_e        kind;
        logic [PC_W-1:0]  target;
    } slot_t;

    logic [ENTRIES-1:0] valid_q;
    slot_t              slot_q [ENTRIES];
    slot_t              rd_slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !rst) begin
            slot_q[wr_idx] <= '{tag: wr_tag, kind: wr_kind, target: wr_target};
        end
    end

    assign rd_slot   = slot_q[rd_idx];
    assign rd_valid  = valid_q[rd_idx];
    assign rd_tag    = rd_slot.tag;
    assign rd_kind   = rd_slot.kind;
    assign rd_target = rd_slot.target;
endmodule

// File: rtl/btt_match.sv
module btt_match
    import btt_pkg::*;
#(
    parameter int unsigned IDX_W = 10,
    localparam int unsigned TAG_W = PC_W - IDX_W
) (
    input  logic             slot_valid,
    input  logic [TAG_W-1:0] slot_tag,
    input  btt_kind_e        slot_kind,
    input  logic [PC_W-1:0]  slot_target,
    input  logic [TAG_W-1:0] req_tag,
    output btt_result_t      res
);
    always_comb begin
        res = btt_miss();
        if (slot_valid && (slot_tag == req_tag)) begin
            res.hit    = 1'b1;
            res.kind   = slot_kind;
            res.target = slot_target;
        end
    end
endmodule

// File: rtl/branch_type_table.sv
module branch_type_table
    import btt_pkg::*;
#(
    parameter int unsigned IDX_W = 10,
    localparam int unsigned TAG_W = PC_W - IDX_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_hit,
    output logic [1:0]      lk_kind,
    output logic [PC_W-1:0] lk_target,
    input  logic            up_en,
    input  logic [PC_W-1:0] up_pc,
    input  logic [1:0]      up_kind,
    input  logic [PC_W-1:0] up_target
);
    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;
    logic             s_valid;
    logic [TAG_W-1:0] s_tag;
    btt_kind_e        s_kind;
    logic [PC_W-1:0]  s_target;
    btt_result_t      res;

    btt_split #(.IDX_W(IDX_W)) u_lk_split (.pc(lk_pc), .idx(lk_idx), .tag(lk_tag));
    btt_split #(.IDX_W(IDX_W)) u_up_split (.pc(up_pc), .idx(up_idx), .tag(up_tag));

    btt_store #(.IDX_W(IDX_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (up_en),
        .wr_idx    (up_idx),
        .wr_tag    (up_tag),
        .wr_kind   (btt_kind_e'(up_kind)),
        .wr_target (up_target),
        .rd_idx    (lk_idx),
        .rd_valid  (s_valid),
        .rd_tag    (s_tag),
        .rd_kind   (s_kind),
        .rd_target (s_target)
    );

    btt_match #(.IDX_W(IDX_W)) u_match (
        .slot_valid  (s_valid),
        .slot_tag    (s_tag),
        .slot_kind   (s_kind),
        .slot_target (s_target),
        .req_tag     (lk_tag),
        .res         (res)
    );

    assign lk_hit    = res.hit;
    assign lk_kind   = res.kind;
    assign lk_target = res.target;
endmodule

// File: rtl/btt_chk.sv
module btt_chk #(
    parameter int unsigned IDX_W = 10
) (
    input logic        clk,
    input logic        rst,
    input logic [31:0] lk_pc,
    input logic        lk_hit,
    input logic [1:0]  lk_kind,
    input logic [31:0] lk_target,
    input logic        up_en,
    input logic [31:0] up_pc,
    input logic [1:0]  up_kind,
    input logic [31:0] up_target
);
    // R1
    empty_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !lk_hit);

    // R9
    miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_kind == 2'b00 && lk_target == 32'h0));

    // R4
    wr_then_rd_chk: assert property (@(posedge clk) disable iff (rst)
        up_en |=> ((lk_pc != $past(up_pc)) ||
                   (lk_hit && lk_kind == $past(up_kind) && lk_target == $past(up_target))));

    // R8
    other_slot_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(lk_pc) &&
         (!$past(up_en) || $past(up_pc[IDX_W-1:0]) != lk_pc[IDX_W-1:0]))
        |-> ($stable(lk_hit) && $stable(lk_kind) && $stable(lk_target)));
endmodule

bind branch_type_table btt_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_kind(lk_kind),
    .lk_target(lk_target), .up_en(up_en), .up_pc(up_pc), .up_kind(up_kind),
    .up_target(up_target)
);

// File: tb/sim_branch_type_table.sv
module sim_branch_type_table;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] lk_pc;
    logic        lk_hit;
    logic [1:0]  lk_kind;
    logic [31:0] lk_target;
    logic        up_en;
    logic [31:0] up_pc;
    logic [1:0]  up_kind;
    logic [31:0] up_target;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    branch_type_table u0 (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_kind(lk_kind),
        .lk_target(lk_target), .up_en(up_en), .up_pc(up_pc), .up_kind(up_kind),
        .up_target(up_target)
    );

    task automatic look(input logic [31:0] pc, input logic eh, input logic [1:0] ek,
                        input logic [31:0] et, input string req);
        lk_pc = pc;
        #1;
        checks++;
        if (lk_hit !== eh || lk_kind !== ek || lk_target !== et) begin
            fails++;
            $display("FAIL %s pc=%h actual hit=%b kind=%b tgt=%h expected hit=%b kind=%b tgt=%h",
                     req, pc, lk_hit, lk_kind, lk_target, eh, ek, et);
        end
    endtask

    task automatic write(input logic [31:0] pc, input logic [1:0] k, input logic [31:0] t);
        @(negedge clk);
        up_en = 1'b1; up_pc = pc; up_kind = k; up_target = t;
        @(negedge clk);
        up_en = 1'b0;
    endtask

    task automatic t_reset();
        look(32'h0000_0000, 0, 2'b00, 32'h0, "R1");
        look(32'h8000_03FF, 0, 2'b00, 32'h0, "R1");
        look(32'h1234_5678, 0, 2'b00, 32'h0, "R9");
    endtask

    task automatic t_write_read();
        write(32'h0000_1040, 2'b01, 32'h0000_2000);
        look(32'h0000_1040, 1, 2'b01, 32'h0000_2000, "R2");
        look(32'h0000_1040, 1, 2'b01, 32'h0000_2000, "R4");
    endtask

    task automatic t_alias();
        // same slot 0x040, different tag
        look(32'h0000_2040, 0, 2'b00, 32'h0, "R3");
        look(32'hFFFF_FC40, 0, 2'b00, 32'h0, "R9");
    endtask

    task automatic t_overwrite();
        write(32'h0000_2040, 2'b10, 32'h0000_9000);
        look(32'h0000_1040, 0, 2'b00, 32'h0, "R5");
        look(32'h0000_2040, 1, 2'b10, 32'h0000_9000, "R5");
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        up_en = 1'b1; up_pc = 32'h0000_3040; up_kind = 2'b11; up_target = 32'hABCD_0000;
        look(32'h0000_2040, 1, 2'b10, 32'h0000_9000, "R6");
        @(negedge clk);
        up_en = 1'b0;
        look(32'h0000_2040, 0, 2'b00, 32'h0, "R6");
        look(32'h0000_3040, 1, 2'b11, 32'hABCD_0000, "R6");
    endtask

    task automatic t_kinds();
        for (int k = 0; k < 4; k++) begin
            write(32'h0010_0000 + 32'(k * 4), 2'(k), 32'h5000_0000 + 32'(k));
        end
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            look(32'h0010_0000 + 32'(k * 4), 1, 2'(k), 32'h5000_0000 + 32'(k), "R7");
        end
    endtask

    task automatic t_edges();
        write(32'h4000_0000, 2'b01, 32'h0000_0111);
        write(32'h4000_03FF, 2'b10, 32'h0000_0222);
        look(32'h4000_0000, 1, 2'b01, 32'h0000_0111, "R8");
        look(32'h4000_03FF, 1, 2'b10, 32'h0000_0222, "R8");
        write(32'h4000_0001, 2'b11, 32'h0000_0333);
        look(32'h4000_0000, 1, 2'b01, 32'h0000_0111, "R8");
        look(32'h4000_03FF, 1, 2'b10, 32'h0000_0222, "R8");
        look(32'h0000_3040, 1, 2'b11, 32'hABCD_0000, "R8");
        look(32'h4000_0400, 0, 2'b00, 32'h0, "R3");
    endtask

    task automatic t_reset_again();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        look(32'h4000_0000, 0, 2'b00, 32'h0, "R1");
        look(32'h0000_3040, 0, 2'b00, 32'h0, "R1");
    endtask

    initial begin
        rst = 1'b1; up_en = 1'b0; up_pc = '0; up_kind = '0; up_target = '0; lk_pc = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_write_read();
        t_alias();
        t_overwrite();
        t_same_cycle();
        t_kinds();
        t_edges();
        t_reset_again();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule